// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block turns a segment-relative effective address into a physical address for a 32-bit core that runs in either a real mode or a protected mode. It holds six segment selector registers. Behind each selector sits a hidden descriptor cache that keeps a 32-bit base, a 20-bit limit and 9 attribute bits. The cache cannot be read from outside. One load operation writes a selector and its descriptor cache together and marks that cache valid. This block does not fetch descriptors from tables in memory.

A small two-state machine holds the protection-enable bit of control register 0. In state `MODE_REAL` the address is the selector shifted left by four plus the low 16 bits of the offset, wrapped to 1 MB. In state `MODE_PROT` the address is the cached base plus the full 32-bit offset. That access is checked against the cached limit, the valid flag and the present attribute. Transition `T_ENTER_PROT` is a control write with the bit set. Transition `T_LEAVE_PROT` is a control write with the bit clear. A control write that matches the current state keeps that state.

Translation is combinational from the access inputs. Paging is not implemented, so the linear address is always presented as the physical address.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset the unit is in `MODE_REAL`, all six selectors are zero and all six descriptor caches are invalid. A real-mode access through any segment then returns the low 16 bits of the offset with no fault.
- R2: Segment index values 0 to 5 select CS, SS, DS, ES, FS and GS in that order. Index 6 or 7 raises `fault` in both modes.
- R3: When `sel_we` is high at a rising edge with an index from 0 to 5, that segment's selector, base, limit and attributes are written and its cache is marked valid. Translations from the next cycle on use the new values.
- R4: When `ctl_we` is high at a rising edge, the state takes `ctl_pe`: a 1 gives `MODE_PROT` (`T_ENTER_PROT`) and a 0 gives `MODE_REAL` (`T_LEAVE_PROT`). With `ctl_we` low the state holds.
- R5: In `MODE_REAL`, `phys_addr` is (selector × 16 + offset[15:0]) modulo 2^20, and bits 31..20 are zero. No limit, valid or present check applies.
- R6: In `MODE_PROT`, an access that passes its checks gives `phys_addr` = base + offset modulo 2^32.
- R7: In `MODE_PROT`, an offset strictly greater than the zero-extended 20-bit limit raises `fault`. An offset equal to the limit is allowed.
- R8: In `MODE_PROT`, an access raises `fault` if the segment's cache is invalid or if attribute bit 7 (present) is 0.
- R9: Whenever `fault` is high, `phys_addr` is zero.
- R10: `pg_en` must be held low. The linear address is output unchanged as the physical address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Write strobe for the protection-enable bit |
| ctl_pe | input | 1 | New protection-enable value |
| sel_we | input | 1 | Selector and descriptor load strobe |
| sel_idx | input | 3 | Segment index for the load |
| sel_val | input | 16 | Selector value to load |
| dsc_base | input | 32 | Descriptor base to cache |
| dsc_limit | input | 20 | Descriptor limit to cache |
| dsc_attr | input | 9 | Descriptor attribute bits to cache (bit 7 = present) |
| acc_seg | input | 3 | Segment index of the access |
| acc_off | input | 32 | Effective address (offset) of the access |
| pg_en | input | 1 | Paging enable, must be held low |
| phys_addr | output | 32 | Physical address, zero when faulting |
| fault | output | 1 | Access fault |

## Verification
The bench builds the block with its default parameters: six segments, 16-bit selectors, 32-bit addresses, a 20-bit limit and the present flag in attribute bit 7. At these sizes it can sweep every segment index, including the two unused codes, against selector values up to 0xFFFF. It drives offsets just below, at and just above each limit, with limits of zero and of the full 20-bit maximum. It also covers the 1 MB real-mode wrap and the 32-bit base-plus-offset wrap, and it computes every expected address arithmetically.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    parameter int SEG_COUNT  = 6;
    parameter int SEG_IDX_W  = 3;
    parameter int ADDR_W     = 32;
    parameter int SEL_W      = 16;
    parameter int LIMIT_W    = 20;
    parameter int ATTR_W     = 9;
    parameter int REAL_W     = 20;
    parameter int REAL_SHIFT = 4;
    parameter int PRESENT_BIT = 7;

    typedef enum logic {
        MODE_REAL = 1'b0,
        MODE_PROT = 1'b1
    } xlate_mode_e;

    typedef struct packed {
        logic [ADDR_W-1:0]  base;
        logic [LIMIT_W-1:0] limit;
        logic [ATTR_W-1:0]  attr;
    } seg_cache_t;

endpackage

// File: rtl/seg_mode_fsm.sv
module seg_mode_fsm
    import seg_xlate_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctl_we,
    input  logic        ctl_pe,
    output xlate_mode_e mode
);

    xlate_mode_e state_q;
    xlate_mode_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MODE_REAL;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: T_ENTER_PROT / T_LEAVE_PROT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_REAL: if (ctl_we && ctl_pe)  state_d = MODE_PROT;
            MODE_PROT: if (ctl_we && !ctl_pe) state_d = MODE_REAL;
            default:   state_d = MODE_REAL;
        endcase
    end

    // outputs
    always_comb begin
        mode = state_q;
    end

endmodule

// File: rtl/seg_desc_bank.sv
module seg_desc_bank
    import seg_xlate_pkg::*;
#(
    parameter int N_SEG = SEG_COUNT,
    parameter int IDX_W = SEG_IDX_W,
    parameter int SW    = SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_we,
    input  logic [IDX_W-1:0] ld_idx,
    input  logic [SW-1:0]    ld_sel,
    input  seg_cache_t       ld_cache,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [SW-1:0]    rd_sel,
    output seg_cache_t       rd_cache,
    output logic             rd_vld,
    output logic             rd_in_range,
    output logic [N_SEG-1:0] vld_vec
);

    logic [SW-1:0] sel_q   [N_SEG];
    seg_cache_t    cache_q [N_SEG];
    logic [N_SEG-1:0] vld_q;

    for (genvar g = 0; g < N_SEG; g++) begin : g_seg
        logic hit;
        assign hit = ld_we && (ld_idx == IDX_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sel_q[g]   <= '0;
                cache_q[g] <= '0;
                vld_q[g]   <= 1'b0;
            end else if (hit) begin
                sel_q[g]   <= ld_sel;
                cache_q[g] <= ld_cache;
                vld_q[g]   <= 1'b1;
            end
        end
    end

    always_comb begin
        rd_sel      = '0;
        rd_cache    = '0;
        rd_vld      = 1'b0;
        rd_in_range = 1'b0;
        for (int i = 0; i < N_SEG; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_sel      = sel_q[i];
                rd_cache    = cache_q[i];
                rd_vld      = vld_q[i];
                rd_in_range = 1'b1;
            end
        end
    end

    assign vld_vec = vld_q;

endmodule

// File: rtl/seg_addr_form.sv
module seg_addr_form
    import seg_xlate_pkg::*;
#(
    parameter int AW    = ADDR_W,
    parameter int SW    = SEL_W,
    parameter int LW    = LIMIT_W,
    parameter int RW    = REAL_W,
    parameter int SHIFT = REAL_SHIFT,
    parameter int PBIT  = PRESENT_BIT
) (
    input  xlate_mode_e   mode,
    input  logic [SW-1:0] sel,
    input  seg_cache_t    cache,
    input  logic          cache_vld,
    input  logic          idx_ok,
    input  logic [AW-1:0] off,
    output logic [AW-1:0] phys,
    output logic          fault
);

    localparam int OFF_LO_W = RW - SHIFT;
    localparam int PAD_W    = AW - RW;
    localparam int LPAD_W   = AW - LW;

    logic [RW-1:0] real_sum;
    logic [AW-1:0] lin_sum;
    logic          over_limit;
    logic          present;
    logic          unused_attr;

    assign real_sum   = {sel, {SHIFT{1'b0}}} + {{SHIFT{1'b0}}, off[OFF_LO_W-1:0]};
    assign lin_sum    = cache.base + off;
    assign over_limit = off > {{LPAD_W{1'b0}}, cache.limit};
    assign present    = cache.attr[PBIT];
    assign unused_attr = ^cache.attr;

    always_comb begin
        phys  = '0;
        fault = 1'b0;
        if (!idx_ok) begin
            fault = 1'b1;
        end else begin
            unique case (mode)
                MODE_REAL: begin
                    phys = {{PAD_W{1'b0}}, real_sum};
                end
                MODE_PROT: begin
                    if (!cache_vld || !present || over_limit) begin
                        fault = 1'b1;
                    end else begin
                        phys = lin_sum;
                    end
                end
                default: fault = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
    import seg_xlate_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctl_we,
    input  logic        ctl_pe,
    input  logic        sel_we,
    input  logic [2:0]  sel_idx,
    input  logic [15:0] sel_val,
    input  logic [31:0] dsc_base,
    input  logic [19:0] dsc_limit,
    input  logic [8:0]  dsc_attr,
    input  logic [2:0]  acc_seg,
    input  logic [31:0] acc_off,
    input  logic        pg_en,
    output logic [31:0] phys_addr,
    output logic        fault
);

    xlate_mode_e          mode_q;
    seg_cache_t           ld_cache;
    seg_cache_t           rd_cache;
    logic [SEL_W-1:0]     rd_sel;
    logic                 rd_vld;
    logic                 rd_in_range;
    logic [SEG_COUNT-1:0] vld_vec;
    logic                 unused_pg;

    // paging is not built; linear address is the physical address
    assign unused_pg = pg_en;

    assign ld_cache.base  = dsc_base;
    assign ld_cache.limit = dsc_limit;
    assign ld_cache.attr  = dsc_attr;

    seg_mode_fsm u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .ctl_we (ctl_we),
        .ctl_pe (ctl_pe),
        .mode   (mode_q)
    );

    seg_desc_bank u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .ld_we       (sel_we),
        .ld_idx      (sel_idx),
        .ld_sel      (sel_val),
        .ld_cache    (ld_cache),
        .rd_idx      (acc_seg),
        .rd_sel      (rd_sel),
        .rd_cache    (rd_cache),
        .rd_vld      (rd_vld),
        .rd_in_range (rd_in_range),
        .vld_vec     (vld_vec)
    );

    seg_addr_form u_form (
        .mode      (mode_q),
        .sel       (rd_sel),
        .cache     (rd_cache),
        .cache_vld (rd_vld),
        .idx_ok    (rd_in_range),
        .off       (acc_off),
        .phys      (phys_addr),
        .fault     (fault)
    );

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk
    import seg_xlate_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ctl_we,
    input logic                 ctl_pe,
    input logic                 sel_we,
    input logic [2:0]           sel_idx,
    input logic [2:0]           acc_seg,
    input logic                 pg_en,
    input logic [31:0]          phys_addr,
    input logic                 fault,
    input xlate_mode_e          mode,
    input logic [SEG_COUNT-1:0] vld_vec
);

    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (mode == MODE_REAL) && (vld_vec == '0));

    a_r2_bad_index: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_seg >= SEG_IDX_W'(SEG_COUNT)) |-> fault);

    a_r3_load_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_we && sel_idx < SEG_IDX_W'(SEG_COUNT))
        |=> ((vld_vec >> $past(sel_idx)) & SEG_COUNT'(1)) != '0);

    a_r4_mode_write: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we |=> (mode == ($past(ctl_pe) ? MODE_PROT : MODE_REAL)));

    a_r4_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_we |=> $stable(mode));

    a_r5_real_1mb: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_REAL) |-> (phys_addr[31:20] == '0));

    a_r9_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (phys_addr == '0));

    a_r10_paging_low: assert property (@(posedge clk) disable iff (!rst_n)
        !pg_en);

endmodule

bind seg_xlate_unit seg_xlate_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_we    (ctl_we),
    .ctl_pe    (ctl_pe),
    .sel_we    (sel_we),
    .sel_idx   (sel_idx),
    .acc_seg   (acc_seg),
    .pg_en     (pg_en),
    .phys_addr (phys_addr),
    .fault     (fault),
    .mode      (mode_q),
    .vld_vec   (vld_vec)
);

// File: tb/seg_xlate_unit_tb.sv
module seg_xlate_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we = 1'b0;
    logic        ctl_pe = 1'b0;
    logic        sel_we = 1'b0;
    logic [2:0]  sel_idx = '0;
    logic [15:0] sel_val = '0;
    logic [31:0] dsc_base = '0;
    logic [19:0] dsc_limit = '0;
    logic [8:0]  dsc_attr = '0;
    logic [2:0]  acc_seg = '0;
    logic [31:0] acc_off = '0;
    logic        pg_en = 1'b0;
    logic [31:0] phys_addr;
    logic        fault;

    always #2 clk = ~clk;

    seg_xlate_unit u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_we    (ctl_we),
        .ctl_pe    (ctl_pe),
        .sel_we    (sel_we),
        .sel_idx   (sel_idx),
        .sel_val   (sel_val),
        .dsc_base  (dsc_base),
        .dsc_limit (dsc_limit),
        .dsc_attr  (dsc_attr),
        .acc_seg   (acc_seg),
        .acc_off   (acc_off),
        .pg_en     (pg_en),
        .phys_addr (phys_addr),
        .fault     (fault)
    );

    int n_vec = 0;
    int n_bad = 0;

    // bench model of the visible state
    logic        m_pe;
    logic [15:0] m_sel  [6];
    logic [31:0] m_base [6];
    logic [19:0] m_lim  [6];
    logic        m_vld  [6];
    logic        m_pres [6];

    task automatic model_reset();
        m_pe = 1'b0;
        for (int i = 0; i < 6; i++) begin
            m_sel[i] = '0; m_base[i] = '0; m_lim[i] = '0;
            m_vld[i] = 1'b0; m_pres[i] = 1'b0;
        end
    endtask

    task automatic do_load(input int idx, input logic [15:0] s, input logic [31:0] b,
                           input logic [19:0] l, input logic [8:0] a);
        @(negedge clk);
        sel_we = 1'b1; sel_idx = 3'(idx); sel_val = s;
        dsc_base = b; dsc_limit = l; dsc_attr = a;
        @(negedge clk);
        sel_we = 1'b0;
        if (idx < 6) begin
            m_sel[idx] = s; m_base[idx] = b; m_lim[idx] = l;
            m_vld[idx] = 1'b1; m_pres[idx] = a[7];
        end
    endtask

    task automatic set_pe(input logic v);
        @(negedge clk);
        ctl_we = 1'b1; ctl_pe = v;
        @(negedge clk);
        ctl_we = 1'b0;
        m_pe = v;
    endtask

    task automatic check(input int idx, input logic [31:0] off, input string tag);
        logic [31:0] e_phys;
        logic        e_fault;
        logic [19:0] rsum;
        @(negedge clk);
        acc_seg = 3'(idx); acc_off = off;
        #1;
        e_phys = '0; e_fault = 1'b0;
        if (idx > 5) begin
            e_fault = 1'b1;
        end else if (!m_pe) begin
            rsum = 20'({4'h0, m_sel[idx]} * 16 + {4'h0, off[15:0]});
            e_phys = {12'h000, rsum};
        end else if (!m_vld[idx] || !m_pres[idx] || off > {12'h000, m_lim[idx]}) begin
            e_fault = 1'b1;
        end else begin
            e_phys = m_base[idx] + off;
        end
        n_vec++;
        if (phys_addr !== e_phys || fault !== e_fault) begin
            n_bad++;
            $display("FAIL %s seg=%0d off=%h: phys=%h fault=%b, expected phys=%h fault=%b",
                     tag, idx, off, phys_addr, fault, e_phys, e_fault);
        end
    endtask

    logic [31:0] offs [6];
    logic [15:0] sels [6];
    logic [19:0] lims [6];

    initial begin
        offs[0] = 32'h0000_0000; offs[1] = 32'h0000_0001; offs[2] = 32'h0000_FFFF;
        offs[3] = 32'h1234_5678; offs[4] = 32'hFFFF_FFFF; offs[5] = 32'h0000_FFF0;
        sels[0] = 16'h0000; sels[1] = 16'h1234; sels[2] = 16'hFFFF;
        sels[3] = 16'h8000; sels[4] = 16'h0FFF; sels[5] = 16'hF000;
        lims[0] = 20'hFFFFF; lims[1] = 20'h00000; lims[2] = 20'h00FFF;
        lims[3] = 20'h12345; lims[4] = 20'h00001; lims[5] = 20'h0FFFF;
        model_reset();

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, real mode, zero selectors
        for (int s = 0; s < 6; s++) check(s, 32'hABCD_1234, "R1 reset real");
        // R1/R8: caches invalid after reset -> protected fault
        set_pe(1'b1);
        for (int s = 0; s < 6; s++) check(s, 32'h0000_0010, "R8 invalid cache");
        // R2: unused codes fault in protected mode
        check(6, 32'h0, "R2 bad index prot");
        check(7, 32'h5, "R2 bad index prot");
        // R4: leave protected mode
        set_pe(1'b0);
        check(0, 32'h0000_4321, "R4 back to real");

        // R3/R5: load selectors, sweep offsets in real mode
        for (int s = 0; s < 6; s++)
            do_load(s, sels[s], 32'h0100_0000 * s + 32'h345, lims[s], 9'h080 | 9'(s));
        for (int s = 0; s < 6; s++)
            for (int o = 0; o < 6; o++) check(s, offs[o], "R5 real form");
        // R5: 1 MB wrap sweep on DS
        for (int v = 0; v < 16; v++) begin
            do_load(2, 16'(v * 16'h1111), 32'h0, 20'h0, 9'h080);
            check(2, 32'h0000_FFFF, "R5 real wrap");
            check(2, 32'hFFFF_0010, "R5 real high offset bits");
        end
        // R2: unused codes fault in real mode; load to unused code is ignored
        check(6, 32'h10, "R2 bad index real");
        do_load(7, 16'h4444, 32'h1, 20'hFFFFF, 9'h080);
        check(7, 32'h10, "R2 load to bad index");

        // R4/R6/R7: protected mode, limit boundaries
        set_pe(1'b1);
        do_load(2, 16'h0010, 32'h0200_0345, lims[2], 9'h080);
        for (int s = 0; s < 6; s++) begin
            check(s, 32'h0, "R6 prot base");
            if (lims[s] != 0) check(s, {12'h0, lims[s]} - 1, "R7 below limit");
            check(s, {12'h0, lims[s]}, "R7 at limit");
            check(s, {12'h0, lims[s]} + 1, "R7 above limit");
            check(s, 32'hFFFF_FFFF, "R7 max offset");
            check(s, 32'h0010_0000, "R7 past 20 bits");
        end
        // R6: 32-bit wrap of base + offset
        do_load(5, 16'h0028, 32'hFFFF_F000, 20'hFFFFF, 9'h093);
        check(5, 32'h0000_1000, "R6 base wrap zero");
        check(5, 32'h0000_2345, "R6 base wrap");
        check(5, 32'h000F_FFFF, "R6 wrap at limit");
        // R8: not-present descriptor
        do_load(3, 16'h0030, 32'h0000_8000, 20'hFFFFF, 9'h07F);
        check(3, 32'h0000_0001, "R8 not present");
        // R3: reload makes it present, visible next cycle
        do_load(3, 16'h0030, 32'h0000_8000, 20'hFFFFF, 9'h080);
        check(3, 32'h0000_0001, "R3 reload");
        // R10: paging held low, linear address out
        check(0, 32'h0000_0ABC, "R10 linear passthrough");
        // R4: control write with same value holds, then leave
        set_pe(1'b1);
        check(4, 32'h0, "R4 hold prot");
        set_pe(1'b0);
        for (int s = 0; s < 6; s++) check(s, 32'h0000_F00F, "R4 real after prot");

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule